// File: doc/BRIEF.md
# Carrier Detect Timing Qualifier

This block turns a raw, unfiltered energy-detect flag from the receive path into a clean, active-low carrier-detect signal. A carrier is declared only after the raw flag has stayed true for a full qualification delay, and withdrawn only after it has stayed false for a full release delay. The two delays differ and come from one of two lookup tables. The table used depends on whether the receiver is in frequency-shift-keyed data operation or touch-tone (DTMF) reception, and a 2-bit timing code per operation selects the entry. Delays are counted in milliseconds from a tick that a divider derives from the master clock.

The qualified state also gates the received data path. While no carrier is declared, the serial received-data output is held at mark (high), and the 4-bit decoded tone code is not driven: a drive-enable output goes low so the pad floats, and the code value reads zero. A power-down input also releases the code pins, even while a carrier is declared.

The default divider of 3580 turns a 3.579545 MHz master clock into an approximate 1 ms tick, and the small rounding error is accepted. The analog level comparison that produces the raw flag lies outside this block.

Top module: `carrier_qualifier`

## Requirements
- R1: During and right after a synchronous active-low reset, `cd_n` is 1, `rxd_q` is 1 and `code_drive` is 0.
- R2: In data mode (`mode_dtmf` = 0), the qualification delay for `fsk_tsel` values 0, 1, 2, 3 is 450, 15, 15, 75 ticks. `cd_n` falls no earlier than (N-1)·TICK_DIV and no later than N·TICK_DIV clock cycles after `det_raw` rises.
- R3: In data mode, the release delay for `fsk_tsel` values 0, 1, 2, 3 is 30, 30, 15, 10 ticks, with the same window rule for the rise of `cd_n` after `det_raw` falls.
- R4: In tone mode (`mode_dtmf` = 1), the qualification delay for `dtmf_tsel` values 0, 1, 2 is 30, 35, 45 ticks.
- R5: In tone mode, the release delay for `dtmf_tsel` values 0, 1, 2 is 25, 35, 25 ticks.
- R6: In tone mode, `dtmf_tsel` value 3 uses the same delays as value 0 (30 to qualify, 25 to release).
- R7: Any cycle in which `det_raw` is false while no carrier is declared clears the qualification count. The full delay is then needed again from the next rise.
- R8: Any cycle in which `det_raw` is true while a carrier is declared clears the release count. The full delay is then needed again from the next fall.
- R9: While `cd_n` is 1, `rxd_q` is 1 whatever `rxd_raw` is. While `cd_n` is 0, `rxd_q` equals `rxd_raw`.
- R10: While `cd_n` is 0 and `sleep` is 0, `code_drive` is 1 and `code_q` equals `code_raw`. While `cd_n` is 1, `code_drive` is 0 and `code_q` is 0.
- R11: While `sleep` is 1, `code_drive` is 0 and `code_q` is 0, even if a carrier is declared. `cd_n` is not affected by `sleep`.
- R12: The millisecond tick occurs exactly once every TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_raw | input | 1 | Unfiltered energy-detect flag, high means energy present |
| mode_dtmf | input | 1 | Selects the delay table: 0 data, 1 tone |
| fsk_tsel | input | 2 | Timing code for data mode |
| dtmf_tsel | input | 2 | Timing code for tone mode |
| sleep | input | 1 | Power-down: releases the code pins |
| rxd_raw | input | 1 | Demodulated received data bit |
| code_raw | input | 4 | Decoded tone code from the tone receiver |
| cd_n | output | 1 | Qualified carrier detect, low when a carrier is declared |
| rxd_q | output | 1 | Gated received data, forced high without carrier |
| code_q | output | 4 | Gated tone code, zero when not driven |
| code_drive | output | 1 | Pad drive enable for the code pins; low means floating |

## Verification
The bench targets the window edges of every table entry in both modes. It samples one tick before the delay runs out and again once it has, so a swapped entry, a table read with the wrong mode, or an off-by-one tick count shows up as an early or late edge. It also checks the unlisted tone code against the code-0 delays, since a design that falls through to another entry would release at the wrong time. A one-cycle dropout one tick before expiry in each direction catches a counter that pauses instead of restarting, because such a design would flip almost at once. The gating checks toggle the received bit and the code while no carrier is declared, then raise `sleep` while one is declared, to catch leakage through the data path.

// File: rtl/cdq_pkg.sv
// Package: shared widths and the delay lookup tables of the carrier qualifier.
// Assumes delays are whole ticks and no entry is zero.
package cdq_pkg;

    localparam int MAX_DELAY = 450;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);

    typedef logic [CNT_W-1:0] delay_t;

    // Qualification delay, data mode.
    function automatic delay_t fsk_on_delay(input logic [1:0] code);
        case (code)
            2'd0:    fsk_on_delay = delay_t'(450);
            2'd1:    fsk_on_delay = delay_t'(15);
            2'd2:    fsk_on_delay = delay_t'(15);
            default: fsk_on_delay = delay_t'(75);
        endcase
    endfunction

    // Release delay, data mode.
    function automatic delay_t fsk_off_delay(input logic [1:0] code);
        case (code)
            2'd0:    fsk_off_delay = delay_t'(30);
            2'd1:    fsk_off_delay = delay_t'(30);
            2'd2:    fsk_off_delay = delay_t'(15);
            default: fsk_off_delay = delay_t'(10);
        endcase
    endfunction

    // Qualification delay, tone mode; code 3 falls back to code 0.
    function automatic delay_t dtmf_on_delay(input logic [1:0] code);
        case (code)
            2'd1:    dtmf_on_delay = delay_t'(35);
            2'd2:    dtmf_on_delay = delay_t'(45);
            default: dtmf_on_delay = delay_t'(30);
        endcase
    endfunction

    // Release delay, tone mode; code 3 falls back to code 0.
    function automatic delay_t dtmf_off_delay(input logic [1:0] code);
        case (code)
            2'd1:    dtmf_off_delay = delay_t'(35);
            default: dtmf_off_delay = delay_t'(25);
        endcase
    endfunction

endpackage

// File: rtl/cdq_tick_gen.sv
// Module: divides the master clock into a one-per-TICK_DIV-cycles tick.
// Assumes TICK_DIV >= 1; with TICK_DIV = 1 the tick is always high.
module cdq_tick_gen #(
    parameter int TICK_DIV = 3580
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

            logic [DW-1:0] div_q;

            // Purpose: free-running divider that wraps at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n)            div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);

            // R12: two ticks are never adjacent when the divider exceeds one.
            a_r12_tick_spacing: assert property (
                @(posedge clk) disable iff (!rst_n) tick |=> !tick
            );
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/cdq_delay_sel.sv
// Module: picks the qualification and release delays for the current mode
// and timing codes. Purely combinational; codes may change at any time.
module cdq_delay_sel
    import cdq_pkg::*;
(
    input  logic       mode_dtmf,
    input  logic [1:0] fsk_tsel,
    input  logic [1:0] dtmf_tsel,
    output delay_t     on_delay,
    output delay_t     off_delay
);

    // Purpose: table lookup steered by the mode select.
    always_comb begin
        if (mode_dtmf) begin
            on_delay  = dtmf_on_delay(dtmf_tsel);
            off_delay = dtmf_off_delay(dtmf_tsel);
        end else begin
            on_delay  = fsk_on_delay(fsk_tsel);
            off_delay = fsk_off_delay(fsk_tsel);
        end
    end

endmodule

// File: rtl/cdq_debounce.sv
// Module: asymmetric debouncer. The state flips only after the raw flag has
// disagreed with it on a run of consecutive ticks equal to the delay for the
// direction of the change. Any cycle of agreement clears the run.
// Assumes delays are nonzero and ticks are single-cycle pulses.
module cdq_debounce
    import cdq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   det_raw,
    input  delay_t on_delay,
    input  delay_t off_delay,
    output logic   active
);

    delay_t           run_q;
    delay_t           target;
    logic             differ;
    logic [CNT_W:0]   run_next;
    logic             expire;

    assign target   = active ? off_delay : on_delay;
    assign differ   = (det_raw != active);
    assign run_next = {1'b0, run_q} + 1'b1;
    assign expire   = tick && differ && (run_next >= {1'b0, target});

    // Purpose: count ticks of disagreement and flip the state on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            run_q  <= '0;
        end else if (!differ) begin
            run_q  <= '0;
        end else if (expire) begin
            active <= ~active;
            run_q  <= '0;
        end else if (tick) begin
            run_q  <= run_next[CNT_W-1:0];
        end
    end

    // R2, R3: the state only ever moves on a tick edge.
    a_r2_flip_on_tick: assert property (
        @(posedge clk) disable iff (!rst_n) !tick |=> $stable(active)
    );

    // R7, R8: one cycle of agreement leaves the run empty.
    a_r7_agree_clears: assert property (
        @(posedge clk) disable iff (!rst_n) !differ |=> (run_q == '0)
    );

    // R3: an unexpired run never changes the state.
    a_r3_no_early_flip: assert property (
        @(posedge clk) disable iff (!rst_n)
        (differ && (run_next < {1'b0, target})) |=> $stable(active)
    );

    // R2: the run never passes the largest delay.
    a_r2_run_bounded: assert property (
        @(posedge clk) disable iff (!rst_n) run_q < delay_t'(MAX_DELAY)
    );

endmodule

// File: rtl/carrier_qualifier.sv
// Module: top of the carrier detect timing qualifier. Combines the tick
// divider, delay selection and debouncer, and gates the received data and
// tone code on the qualified state.
// Assumes all inputs are synchronous to clk.
module carrier_qualifier
    import cdq_pkg::*;
#(
    parameter int TICK_DIV = 3580
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det_raw,
    input  logic       mode_dtmf,
    input  logic [1:0] fsk_tsel,
    input  logic [1:0] dtmf_tsel,
    input  logic       sleep,
    input  logic       rxd_raw,
    input  logic [3:0] code_raw,
    output logic       cd_n,
    output logic       rxd_q,
    output logic [3:0] code_q,
    output logic       code_drive
);

    logic   tick;
    logic   active;
    delay_t on_delay;
    delay_t off_delay;

    cdq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cdq_delay_sel u_sel (
        .mode_dtmf (mode_dtmf),
        .fsk_tsel  (fsk_tsel),
        .dtmf_tsel (dtmf_tsel),
        .on_delay  (on_delay),
        .off_delay (off_delay)
    );

    cdq_debounce u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .det_raw   (det_raw),
        .on_delay  (on_delay),
        .off_delay (off_delay),
        .active    (active)
    );

    // Purpose: output gating on the qualified state and power-down.
    always_comb begin
        cd_n       = ~active;
        rxd_q      = active ? rxd_raw : 1'b1;
        code_drive = active && !sleep;
        code_q     = code_drive ? code_raw : 4'h0;
    end

    // R1: the cycle after a reset shows no carrier.
    a_r1_reset_idle: assert property (
        @(posedge clk) !rst_n |=> cd_n
    );

    // R9: no carrier means mark on the data output.
    a_r9_mark_hold: assert property (
        @(posedge clk) disable iff (!rst_n) cd_n |-> rxd_q
    );

    // R10, R11: the code pins are driven only with a carrier and no sleep.
    a_r10_drive_needs_cd: assert property (
        @(posedge clk) disable iff (!rst_n) code_drive |-> (!cd_n && !sleep)
    );

endmodule

// File: tb/carrier_qualifier_bench.sv
// Bench: scoreboard-style. Driver tasks push expected output items into a
// queue with the cycle they fall due; a monitor pops and compares them.
module carrier_qualifier_bench;

    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_raw = 1'b0;
    logic       mode_dtmf = 1'b0;
    logic [1:0] fsk_tsel = 2'd0;
    logic [1:0] dtmf_tsel = 2'd0;
    logic       sleep = 1'b0;
    logic       rxd_raw = 1'b0;
    logic [3:0] code_raw = 4'hA;
    logic       cd_n;
    logic       rxd_q;
    logic [3:0] code_q;
    logic       code_drive;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        bit         cdn;
        bit         rxd;
        bit         drv;
        logic [3:0] code;
        string      tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    carrier_qualifier #(.TICK_DIV(DIV)) u_carrier_qualifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_raw    (det_raw),
        .mode_dtmf  (mode_dtmf),
        .fsk_tsel   (fsk_tsel),
        .dtmf_tsel  (dtmf_tsel),
        .sleep      (sleep),
        .rxd_raw    (rxd_raw),
        .code_raw   (code_raw),
        .cd_n       (cd_n),
        .rxd_q      (rxd_q),
        .code_q     (code_q),
        .code_drive (code_drive)
    );

    // Expected-output model built from the requirements, for a given cd_n.
    task automatic expect_at(input int m, input bit cdn, input string tag);
        item_t it;
        it.due  = cyc + m;
        it.cdn  = cdn;
        it.rxd  = cdn ? 1'b1 : rxd_raw;
        it.drv  = !cdn && !sleep;
        it.code = it.drv ? code_raw : 4'h0;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Drive the raw flag to lvl; check the old state one tick before expiry
    // and the new state once n ticks have passed.
    task automatic transition(input int n, input bit lvl, input string tag);
        det_raw = lvl;
        expect_at((n - 1) * DIV, lvl, tag);
        expect_at(n * DIV, !lvl, tag);
        hold(n * DIV + 1);
        hold(2);
    endtask

    // Disagree for n-1 ticks, agree one cycle, then require the full delay.
    task automatic dropout(input int n, input bit lvl, input string tag);
        det_raw = lvl;
        hold((n - 1) * DIV);
        det_raw = !lvl;
        expect_at(1, lvl, tag);
        hold(1);
        transition(n, lvl, tag);
    endtask

    // Monitor: count cycles and compare every item that falls due.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    checks++;
                    if (cd_n !== sb[i].cdn || rxd_q !== sb[i].rxd ||
                        code_drive !== sb[i].drv || code_q !== sb[i].code) begin
                        errors++;
                        $display("FAIL %s cyc %0d: cd_n/rxd/drv/code = %b/%b/%b/%h expected %b/%b/%b/%h",
                                 sb[i].tag, cyc, cd_n, rxd_q, code_drive, code_q,
                                 sb[i].cdn, sb[i].rxd, sb[i].drv, sb[i].code);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        int fsk_on[4]   = '{450, 15, 15, 75};
        int fsk_off[4]  = '{30, 30, 15, 10};
        int dtmf_on[4]  = '{30, 35, 45, 30};
        int dtmf_off[4] = '{25, 35, 25, 25};

        hold(3);
        expect_at(0 + 1, 1'b1, "R1 reset idle");
        rst_n = 1'b1;
        hold(2);

        // R2 and R3: data-mode table, every code.
        for (int c = 0; c < 4; c++) begin
            fsk_tsel = 2'(c);
            transition(fsk_on[c], 1'b1, "R2 data qualify");
            transition(fsk_off[c], 1'b0, "R3 data release");
        end

        // R4, R5 and R6: tone-mode table, code 3 checked against code 0.
        mode_dtmf = 1'b1;
        for (int c = 0; c < 4; c++) begin
            dtmf_tsel = 2'(c);
            transition(dtmf_on[c], 1'b1, c == 3 ? "R6 tone code3 qualify" : "R4 tone qualify");
            transition(dtmf_off[c], 1'b0, c == 3 ? "R6 tone code3 release" : "R5 tone release");
        end

        // R9 and R10: gating while idle, with data and code toggled.
        mode_dtmf = 1'b0;
        fsk_tsel  = 2'd1;
        rxd_raw   = 1'b0;
        code_raw  = 4'h3;
        expect_at(1, 1'b1, "R9 mark while idle");
        hold(2);
        rxd_raw = 1'b1;
        expect_at(1, 1'b1, "R10 code released while idle");
        hold(2);
        rxd_raw = 1'b0;

        // R7: dropout during qualification restarts the count.
        dropout(15, 1'b1, "R7 qualify restart");

        // R9, R10: pass-through while a carrier is declared.
        rxd_raw = 1'b1;
        expect_at(1, 1'b0, "R9 data passes");
        hold(2);
        rxd_raw  = 1'b0;
        code_raw = 4'h5;
        expect_at(1, 1'b0, "R10 code driven");
        hold(2);

        // R11: sleep releases the code pins but keeps the carrier.
        sleep = 1'b1;
        expect_at(1, 1'b0, "R11 sleep releases code");
        hold(2);
        sleep = 1'b0;
        expect_at(1, 1'b0, "R11 wake drives code");
        hold(2);

        // R8: dropout during release restarts the count.
        dropout(30, 1'b0, "R8 release restart");

        hold(4);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard: %0d items never compared, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule